// File: doc/BRIEF.md
# Flash Protected-Range Address Checker

This block guards a serial flash device against stray accesses. It holds a small set of protected-range registers. Each register describes one window of the flash address space by a lower and an upper page number, and carries one enable for reading and one for modification. Modification covers both program and erase. Every access request is checked against all windows at the same time. A request that falls inside an enabled window is flagged as a violation in the same cycle. The index of the lowest-numbered matching window is reported with it.

Software may load the registers freely after reset. A lock-down input freezes them until the next reset. Protection is enforced only once the lock is in place. Before lock-down no request is ever flagged, whatever the registers hold. The flash signalling and the host bus decoding sit outside this block. The block only stores the ranges, handles the lock and makes the per-request decision.

Each range register is 32 bits wide:
- Bit 31 is the modify-protect enable.
- Bits 28:16 hold the upper page, which is address bits 24:12. The low 12 bits of the upper bound are taken as all ones.
- Bit 15 is the read-protect enable.
- Bits 12:0 hold the lower page, which is address bits 24:12. The low 12 bits of the lower bound are taken as zero.
- Bits 30:29 and 14:13 always read as zero.

Top module: `flash_range_guard`

## Requirements
- R1: After reset every range register reads 0x00000000, `locked` is 0 and `viol` is 0.
- R2: A write while unlocked to index 0..4 stores `cfg_wdata` with bits 30:29 and 14:13 forced to zero, and the value reads back through `cfg_ridx`/`cfg_rdata` in the cycle after the write edge. A write to an index of 5 or more changes no register, and reading such an index returns zero.
- R3: `locked` rises at the first clock edge where `lock_in` is high and stays high until reset, whatever `lock_in` does afterwards.
- R4: Once locked, writes leave every register unchanged. A write presented in the same cycle as `lock_in` is also discarded.
- R5: While `locked` is 0, `viol` is 0 for every request.
- R6: When locked, a valid request of kind write (code 1) or erase (code 2) is a violation if some range has bit 31 set and lower ≤ address ≤ upper.
- R7: When locked, a valid read request (kind code 0) is a violation only through ranges with bit 15 set. Bit 15 has no effect on writes or erases, and bit 31 has no effect on reads.
- R8: Bounds are inclusive: {lower page, 0x000} and {upper page, 0xFFF} both match, and the addresses one below and one above do not. A range whose lower page is above its upper page matches nothing.
- R9: `viol_idx` gives the lowest-numbered matching range while `viol` is 1, and is 0 while `viol` is 0.
- R10: With `req_valid` low, or with kind code 3, `viol` is 0.
- R11: `viol` and `viol_idx` are combinational outputs of the current request, valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Range register write strobe |
| cfg_idx | input | 3 | Index of the register to write |
| cfg_wdata | input | 32 | Write data |
| cfg_ridx | input | 3 | Index of the register to read |
| cfg_rdata | output | 32 | Read data for `cfg_ridx` |
| lock_in | input | 1 | Lock-down request |
| locked | output | 1 | Registers frozen and protection enforced |
| req_valid | input | 1 | Access request present |
| req_addr | input | 25 | Flash byte address of the request |
| req_kind | input | 2 | 0 read, 1 write, 2 erase, 3 none |
| viol | output | 1 | Request hits an enabled protected range |
| viol_idx | output | 3 | Lowest matching range index |

## Verification
A corrupted range register shows at the ports in two ways. It shows at once on `cfg_rdata`. It also shows as a missing or extra violation the first time a request lands near a bound, which is why the stimulus concentrates on the pages on either side of each limit. A lock flag that drops or never sets shows in the same cycle as a silent `viol` on a covered address. It also shows as a register that keeps changing after lock-down, which readback of each register after a late write attempt detects. A wrong priority order shows only where ranges overlap, so two overlapping pairs are configured, one for reads and one for all kinds.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  localparam int REG_W       = 32;
  localparam int FLASH_ADDR_W = 25;
  localparam int PAGE_BITS   = 12;
  localparam int PAGE_W      = FLASH_ADDR_W - PAGE_BITS;

  // bits 30:29 and 14:13 are never stored
  localparam logic [REG_W-1:0] KEEP_MASK = 32'h9FFF_9FFF;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_ERASE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic              mod_prot;   // bit 31
    logic [1:0]        pad_hi;     // bits 30:29
    logic [PAGE_W-1:0] top_page;   // bits 28:16
    logic              rd_prot;    // bit 15
    logic [1:0]        pad_lo;     // bits 14:13
    logic [PAGE_W-1:0] base_page;  // bits 12:0
  } range_word_t;

  function automatic range_word_t clean_word(input logic [REG_W-1:0] raw);
    return range_word_t'(raw & KEEP_MASK);
  endfunction

  function automatic logic [FLASH_ADDR_W-1:0] floor_addr(input logic [PAGE_W-1:0] pg);
    return {pg, {PAGE_BITS{1'b0}}};
  endfunction

  function automatic logic [FLASH_ADDR_W-1:0] ceil_addr(input logic [PAGE_W-1:0] pg);
    return {pg, {PAGE_BITS{1'b1}}};
  endfunction

  function automatic logic kind_guarded(input acc_kind_e k, input logic rd_en,
                                        input logic mod_en);
    case (k)
      ACC_READ:              return rd_en;
      ACC_WRITE, ACC_ERASE:  return mod_en;
      default:               return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fpr_reg_bank.sv
module fpr_reg_bank
  import fpr_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int IDX_W      = $clog2(NUM_RANGES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic [REG_W-1:0]              cfg_wdata,
  input  logic [IDX_W-1:0]              cfg_ridx,
  output logic [REG_W-1:0]              cfg_rdata,
  input  logic                          lock_in,
  output logic                          locked,
  output logic [NUM_RANGES-1:0]         mod_vec,
  output logic [NUM_RANGES-1:0]         rd_vec,
  output logic [NUM_RANGES*PAGE_W-1:0]  base_flat,
  output logic [NUM_RANGES*PAGE_W-1:0]  top_flat
);

  range_word_t regs_q [NUM_RANGES];
  logic        lock_q;
  logic        wr_open;

  // a lock request in flight already closes the write path
  assign wr_open = cfg_we && !lock_q && !lock_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else if (lock_in) lock_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_open && (cfg_idx == IDX_W'(g))) begin
        regs_q[g] <= clean_word(cfg_wdata);
      end
    end
    assign mod_vec[g]                      = regs_q[g].mod_prot;
    assign rd_vec[g]                       = regs_q[g].rd_prot;
    assign base_flat[g*PAGE_W +: PAGE_W]   = regs_q[g].base_page;
    assign top_flat[g*PAGE_W +: PAGE_W]    = regs_q[g].top_page;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (cfg_ridx == IDX_W'(i)) cfg_rdata = regs_q[i];
    end
  end

  assign locked = lock_q;

endmodule

// File: rtl/fpr_range_cmp.sv
module fpr_range_cmp
  import fpr_pkg::*;
(
  input  logic [FLASH_ADDR_W-1:0] addr,
  input  acc_kind_e               kind,
  input  logic [PAGE_W-1:0]       base_page,
  input  logic [PAGE_W-1:0]       top_page,
  input  logic                    rd_en,
  input  logic                    mod_en,
  output logic                    hit
);

  logic above_floor;
  logic below_ceil;
  logic guarded;

  assign above_floor = addr >= floor_addr(base_page);
  assign below_ceil  = addr <= ceil_addr(top_page);
  assign guarded     = kind_guarded(kind, rd_en, mod_en);
  assign hit         = guarded && above_floor && below_ceil;

endmodule

// File: rtl/fpr_prio_pick.sv
module fpr_prio_pick #(
  parameter int N     = 5,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
  import fpr_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int IDX_W      = $clog2(NUM_RANGES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  logic [31:0]             cfg_wdata,
  input  logic [IDX_W-1:0]        cfg_ridx,
  output logic [31:0]             cfg_rdata,
  input  logic                    lock_in,
  output logic                    locked,
  input  logic                    req_valid,
  input  logic [24:0]             req_addr,
  input  logic [1:0]              req_kind,
  output logic                    viol,
  output logic [IDX_W-1:0]        viol_idx
);

  logic [NUM_RANGES-1:0]         mod_vec;
  logic [NUM_RANGES-1:0]         rd_vec;
  logic [NUM_RANGES*PAGE_W-1:0]  base_flat;
  logic [NUM_RANGES*PAGE_W-1:0]  top_flat;
  logic [NUM_RANGES-1:0]         hit_vec;
  logic                          any_hit;
  logic [IDX_W-1:0]              first_hit;
  acc_kind_e                     kind_e;
  logic                          enforce;

  assign kind_e = acc_kind_e'(req_kind);

  fpr_reg_bank #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_ridx  (cfg_ridx),
    .cfg_rdata (cfg_rdata),
    .lock_in   (lock_in),
    .locked    (locked),
    .mod_vec   (mod_vec),
    .rd_vec    (rd_vec),
    .base_flat (base_flat),
    .top_flat  (top_flat)
  );

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
    fpr_range_cmp u_cmp (
      .addr      (req_addr),
      .kind      (kind_e),
      .base_page (base_flat[g*PAGE_W +: PAGE_W]),
      .top_page  (top_flat[g*PAGE_W +: PAGE_W]),
      .rd_en     (rd_vec[g]),
      .mod_en    (mod_vec[g]),
      .hit       (hit_vec[g])
    );
  end

  fpr_prio_pick #(.N(NUM_RANGES), .IDX_W(IDX_W)) u_pick (
    .req (hit_vec),
    .any (any_hit),
    .idx (first_hit)
  );

  assign enforce  = locked && req_valid;
  assign viol     = enforce && any_hit;
  assign viol_idx = viol ? first_hit : '0;

endmodule

// File: rtl/fpr_checker.sv
module fpr_checker
  import fpr_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int IDX_W      = $clog2(NUM_RANGES)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         lock_in,
  input logic                         locked,
  input logic [31:0]                  cfg_rdata,
  input logic                         req_valid,
  input logic [1:0]                   req_kind,
  input logic                         viol,
  input logic [IDX_W-1:0]             viol_idx,
  input logic [NUM_RANGES-1:0]        hit_vec,
  input logic [NUM_RANGES-1:0]        mod_vec,
  input logic [NUM_RANGES-1:0]        rd_vec,
  input logic [NUM_RANGES*PAGE_W-1:0] base_flat,
  input logic [NUM_RANGES*PAGE_W-1:0] top_flat
);

  p_pad_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~KEEP_MASK) == '0);

  p_lock_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_in |=> locked);

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_frozen_regs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(mod_vec) && $stable(rd_vec) &&
                $stable(base_flat) && $stable(top_flat)));

  p_quiet_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !viol);

  p_idx_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |-> (viol_idx == '0));

  p_idx_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (((hit_vec >> viol_idx) & NUM_RANGES'(1)) != '0) &&
             ((hit_vec & ((NUM_RANGES'(1) << viol_idx) - NUM_RANGES'(1))) == '0));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_kind == 2'd3) |-> !viol);

  p_hit_means_viol_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && req_valid && (hit_vec != '0)) |-> viol);

endmodule

bind flash_range_guard fpr_checker #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lock_in   (lock_in),
  .locked    (locked),
  .cfg_rdata (cfg_rdata),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .viol      (viol),
  .viol_idx  (viol_idx),
  .hit_vec   (hit_vec),
  .mod_vec   (mod_vec),
  .rd_vec    (rd_vec),
  .base_flat (base_flat),
  .top_flat  (top_flat)
);

// File: tb/flash_range_guard_test.sv
module flash_range_guard_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  cfg_ridx = '0;
  logic [31:0] cfg_rdata;
  logic        lock_in = 1'b0;
  logic        locked;
  logic        req_valid = 1'b0;
  logic [24:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        viol;
  logic [2:0]  viol_idx;

  int checks = 0;
  int fails  = 0;
  logic [31:0] shadow [5];
  bit          shadow_lock = 0;

  flash_range_guard uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata),
    .lock_in(lock_in), .locked(locked), .req_valid(req_valid),
    .req_addr(req_addr), .req_kind(req_kind), .viol(viol), .viol_idx(viol_idx)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected winner from byte-address arithmetic; -1 when no violation
  function automatic int expect_hit(input bit v, input int addr, input int kind);
    if (!v || !shadow_lock || kind == 3) return -1;
    for (int i = 0; i < 5; i++) begin
      int lo_b, hi_b;
      bit en;
      lo_b = int'(shadow[i][12:0]) * 4096;
      hi_b = int'(shadow[i][28:16]) * 4096 + 4095;
      en   = (kind == 0) ? shadow[i][15] : shadow[i][31];
      if (en && addr >= lo_b && addr <= hi_b) return i;
    end
    return -1;
  endfunction

  task automatic reg_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 5 && !shadow_lock) shadow[idx] = d & 32'h9FFF_9FFF;
  endtask

  task automatic readback(input string req);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] e;
      @(negedge clk);
      cfg_ridx = 3'(i);
      #1;
      e = (i < 5) ? shadow[i] : 32'h0;
      check(cfg_rdata === e, req, cfg_rdata, e);
    end
  endtask

  task automatic probe(input bit v, input int addr, input int kind, input string req);
    int w;
    @(negedge clk);
    req_valid = v; req_addr = 25'(addr); req_kind = 2'(kind);
    #1;
    w = expect_hit(v, addr, kind);
    check(viol === (w >= 0), req, viol, w >= 0);
    check(viol_idx === ((w >= 0) ? 3'(w) : 3'd0), req, viol_idx, (w >= 0) ? w : 0);
  endtask

  function automatic logic [31:0] mk(input bit mp, input bit rp, input int lo, input int hi);
    return {mp, 2'b00, 13'(hi), rp, 2'b00, 13'(lo)};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    shadow_lock = 0;
    for (int i = 0; i < 5; i++) shadow[i] = '0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    do_reset();
    // R1 reset state
    check(locked === 1'b0, "R1 locked", locked, 0);
    readback("R1 reset readback");
    probe(1, 32'h0001000, 1, "R1 viol after reset");

    // R2 reserved bits dropped, out-of-range index ignored
    reg_write(0, 32'hFFFF_FFFF);
    reg_write(6, 32'h1234_5678);
    readback("R2 masked store");
    for (int n = 0; n < 20; n++) reg_write($urandom_range(0, 7), $urandom);
    readback("R2 random store");

    // final layout: overlaps 0/1 (page 0x18..0x1F) and 2/4 (page 0x100)
    reg_write(0, mk(1, 0, 13'h010, 13'h01F));
    reg_write(1, mk(0, 1, 13'h018, 13'h020));
    reg_write(2, mk(1, 1, 13'h100, 13'h100));
    reg_write(3, mk(1, 1, 13'h050, 13'h040));
    reg_write(4, mk(1, 1, 13'h0F0, 13'h1FFF));
    readback("R2 layout");

    // R5 no enforcement before lock
    for (int n = 0; n < 40; n++)
      probe(1, $urandom_range(0, 32'h1FF_FFFF), $urandom_range(0, 2), "R5 unlocked");

    // R3/R4 lock with a write in the same cycle
    @(negedge clk);
    lock_in = 1'b1; cfg_we = 1'b1; cfg_idx = 3'd3; cfg_wdata = 32'h0;
    #1;
    check(locked === 1'b0, "R3 not yet locked", locked, 0);
    @(negedge clk);
    lock_in = 1'b0; cfg_we = 1'b0;
    shadow_lock = 1;
    #1;
    check(locked === 1'b1, "R3 locked after edge", locked, 1);
    readback("R4 same-cycle write dropped");

    // directed corners
    probe(1, 32'h0010000, 1, "R6 write at lower bound");
    probe(1, 32'h000FFFF, 1, "R8 write just below");
    probe(1, 32'h001FFFF, 2, "R6 erase at upper bound");
    probe(1, 32'h0020000, 1, "R8 write just above");
    probe(1, 32'h0010000, 0, "R7 read on modify-only range");
    probe(1, 32'h0020000, 0, "R7 read on read range");
    probe(1, 32'h0021000, 0, "R8 read just above");
    probe(1, 32'h0018000, 1, "R9 overlap write");
    probe(1, 32'h0018000, 0, "R9 overlap read idx1");
    probe(1, 32'h0100800, 0, "R9 overlap idx2");
    probe(1, 32'h00F0000, 2, "R9 idx4");
    probe(1, 32'h0045000, 1, "R8 inverted range");
    probe(1, 32'h0018000, 3, "R10 kind none");
    probe(0, 32'h0018000, 1, "R10 not valid");
    probe(1, 32'h1FFFFFF, 0, "R11 top address");

    // random enforced traffic, biased to bound pages
    for (int n = 0; n < 400; n++) begin
      int pg;
      case ($urandom_range(0, 3))
        0: pg = $urandom_range(32'h00E, 32'h022);
        1: pg = $urandom_range(32'h0EE, 32'h102);
        2: pg = $urandom_range(32'h03E, 32'h052);
        default: pg = $urandom_range(0, 32'h1FFF);
      endcase
      probe($urandom_range(0, 7) != 0, pg * 4096 + $urandom_range(0, 4095),
            $urandom_range(0, 3), "R11 random");
    end

    // R4 writes after lock, R3 lock holds
    for (int i = 0; i < 5; i++) reg_write(i, 32'h0);
    readback("R4 frozen");
    check(locked === 1'b1, "R3 sticky", locked, 1);

    do_reset();
    check(locked === 1'b0, "R1 relock cleared", locked, 0);
    readback("R1 second reset");
    probe(1, 32'h0010000, 1, "R5 after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule